// File: doc/BRIEF.md
# Pixel-Clock Divider Search Unit

This unit takes a requested pixel clock in kHz and works out the divider settings for a display clock synthesiser fed from a fixed 96 MHz reference. After a one-cycle `start`, it first chooses a DAC multiplier from the pixel clock and multiplies the two to get the target frequency. It then walks a fixed, ordered space of divider combinations. For each combination it screens the coupled limits, derives the output (dot) clock with an iterative divider, and compares that clock with the target.

An exact hit ends the walk at once. Otherwise the unit keeps the candidate whose dot clock is nearest to the target while lying strictly above it. When the walk ends, `done` pulses for one cycle. The chosen dividers, the multiplier and the packed divisor word then stay on the outputs until the next accepted `start`. Writing the values into the synthesiser and waiting for lock are left to the caller.

Top module: `pll_div_search`

## Requirements
- R1: The multiplier is 1 for a pixel clock of 100000 kHz or more, 2 for 50000 to 99999 kHz and 4 below that. The target is the pixel clock in Hz times the multiplier. `mult_o` shows the multiplier once a result is found.
- R2: A pixel clock below 25000 kHz is refused. `done` pulses in the cycle after `start`, `bad_clk` goes high, `found` stays low, all result outputs are zero and `busy` never rises.
- R3: A reported result satisfies n in 3..8, m1 in 10..20, m2 in 5..9, p1 in 1..8, m1 > m2, m = 5*m1+m2 in 70..120 and p = 10*p1 in 5..80. It also satisfies VCO = floor(96e6*m/n) in 1.4e9..2.8e9 Hz and dot = floor(VCO/p) in 20e6..400e6 Hz.
- R4: Candidates are visited with n rising (outermost loop), then m1 falling, then m2 falling, then p1 falling (innermost loop). The first legal candidate whose dot clock equals the target is reported.
- R5: Without an exact hit, the reported candidate has the smallest dot-minus-target among legal candidates with dot strictly above the target. The running best starts at 0xFFFFFFFF and is replaced only by a strictly smaller difference, so on a tie the earliest candidate in walk order wins.
- R6: `div_word` holds m2-2 in bits 7:0, m1-2 in bits 15:8 and n-2 in bits 23:16.
- R7: When no candidate qualifies, `done` pulses with `found` low and every result output zero, including `mult_o`, `p2_o` and `div_word`.
- R8: `p2_o` is 10 whenever `found` is high.
- R9: A `start` that arrives while `busy` is high is ignored, and the search that is running completes with its own result.
- R10: After reset, `busy`, `done`, `found` and `bad_clk` are low and all result outputs are zero.
- R11: `busy` is high from the cycle after an accepted `start` until the search ends. `done` is a one-cycle pulse raised while `busy` is low. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search with `pix_khz` (accepted when idle) |
| pix_khz | input | 20 | Requested pixel clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A qualifying candidate was found |
| bad_clk | output | 1 | Last request was below 25000 kHz |
| n_o | output | 8 | Chosen reference pre-divider n |
| m1_o | output | 8 | Chosen coarse feedback divider m1 |
| m2_o | output | 8 | Chosen fine feedback divider m2 |
| p1_o | output | 8 | Chosen post-divider p1 |
| p2_o | output | 8 | Fixed post-divider p2 (10) |
| mult_o | output | 3 | Chosen DAC multiplier |
| div_word | output | 24 | Packed divisor word |

## Verification
Two events can share a cycle here: the end-of-search `done` pulse and a new `start`. The bench holds `start` high in the very cycle it sees `done`. It compares the finished result, which must still be on the outputs, against its own model. It then requires `busy` one cycle later and a correct second result for the new pixel clock. The sweep also covers a `start` in the middle of a search that must be ignored, an exact hit, nearest-above searches in all three multiplier bands, the refusal threshold and a target that no candidate can exceed.

// File: rtl/pll_search_pkg.sv
// Shared limits, widths and types for the divider search unit.
// Assumes a fixed 96 MHz reference and a fixed p2 of 10.
package pll_search_pkg;
    localparam longint unsigned REF_HZ  = 64'd96_000_000;
    localparam int P2_FIX  = 10;
    localparam int N_MIN   = 3;
    localparam int N_MAX   = 8;
    localparam int M_MIN   = 70;
    localparam int M_MAX   = 120;
    localparam int M1_MIN  = 10;
    localparam int M1_MAX  = 20;
    localparam int M2_MIN  = 5;
    localparam int M2_MAX  = 9;
    localparam int P_MIN   = 5;
    localparam int P_MAX   = 80;
    localparam int P1_MIN  = 1;
    localparam int P1_MAX  = 8;
    localparam longint unsigned DOT_MIN = 64'd20_000_000;
    localparam longint unsigned DOT_MAX = 64'd400_000_000;
    localparam longint unsigned VCO_MIN = 64'd1_400_000_000;
    localparam longint unsigned VCO_MAX = 64'd2_800_000_000;

    localparam int FW  = 8;       // width of one divider field
    localparam int WW  = 3 * FW;  // packed divisor word width
    localparam int AW  = 36;      // dividend width (REF_HZ * m)
    localparam int DVW = 10;      // divisor width (n * p)
    localparam int TW  = 32;      // target / difference width

    typedef logic [FW-1:0] fld_t;

    typedef struct packed {
        fld_t n;
        fld_t m1;
        fld_t m2;
        fld_t p1;
    } cand_t;

    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_DIV} st_t;
endpackage

// File: rtl/pll_mult_select.sv
// Chooses the DAC multiplier from the pixel clock and forms the target in Hz.
// Purely combinational; flags requests below the 25 MHz floor.
module pll_mult_select #(
    parameter int PIX_W = 20,
    parameter int TW    = 32
) (
    input  logic [PIX_W-1:0] pix_khz,
    output logic [2:0]       mult,
    output logic [TW-1:0]    target_hz,
    output logic             too_slow
);
    localparam logic [PIX_W-1:0] K_FLOOR = PIX_W'(25000);
    localparam logic [PIX_W-1:0] K_MID   = PIX_W'(50000);
    localparam logic [PIX_W-1:0] K_HIGH  = PIX_W'(100000);

    // Band selection and target product.
    always_comb begin
        if (pix_khz >= K_HIGH)     mult = 3'd1;
        else if (pix_khz >= K_MID) mult = 3'd2;
        else                       mult = 3'd4;
        too_slow  = (pix_khz < K_FLOOR);
        target_hz = TW'(64'(pix_khz) * 64'd1000 * 64'(mult));
    end
endmodule

// File: rtl/pll_cand_walker.sv
// Steps through the divider space in a fixed order: n rising outermost,
// then m1, m2 and p1 falling. Holds its position while step is low.
module pll_cand_walker
    import pll_search_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  step,
    output cand_t cand,
    output logic  last
);
    localparam cand_t FIRST = '{n: FW'(N_MIN), m1: FW'(M1_MAX), m2: FW'(M2_MAX), p1: FW'(P1_MAX)};

    // Position register with nested wrap-around counting.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cand <= FIRST;
        end else if (step) begin
            if (cand.p1 > FW'(P1_MIN)) begin
                cand.p1 <= cand.p1 - 1'b1;
            end else begin
                cand.p1 <= FW'(P1_MAX);
                if (cand.m2 > FW'(M2_MIN)) begin
                    cand.m2 <= cand.m2 - 1'b1;
                end else begin
                    cand.m2 <= FW'(M2_MAX);
                    if (cand.m1 > FW'(M1_MIN)) begin
                        cand.m1 <= cand.m1 - 1'b1;
                    end else begin
                        cand.m1 <= FW'(M1_MAX);
                        cand.n  <= cand.n + 1'b1;
                    end
                end
            end
        end
    end

    // Final position of the walk.
    always_comb last = (cand.n == FW'(N_MAX)) && (cand.m1 == FW'(M1_MIN)) &&
                       (cand.m2 == FW'(M2_MIN)) && (cand.p1 == FW'(P1_MIN));
endmodule

// File: rtl/pll_cand_check.sv
// Screens a candidate on every limit that needs no division (m, p, m1>m2,
// VCO window via cross-multiplication) and prepares the dot-clock division.
module pll_cand_check
    import pll_search_pkg::*;
(
    input  cand_t           cand,
    output logic            ok,
    output logic [AW-1:0]   dividend,
    output logic [DVW-1:0]  divisor
);
    logic [63:0] m_v, p_v, n_v, a_v;

    // floor(a/n) in [lo,hi]  <=>  a >= lo*n  and  a < (hi+1)*n.
    always_comb begin
        m_v = 64'(cand.m1) * 64'd5 + 64'(cand.m2);
        p_v = 64'(cand.p1) * 64'(P2_FIX);
        n_v = 64'(cand.n);
        a_v = REF_HZ * m_v;
        ok  = (cand.m1 > cand.m2) &&
              (m_v >= 64'(M_MIN)) && (m_v <= 64'(M_MAX)) &&
              (p_v >= 64'(P_MIN)) && (p_v <= 64'(P_MAX)) &&
              (a_v >= VCO_MIN * n_v) && (a_v < (VCO_MAX + 64'd1) * n_v);
        dividend = AW'(a_v);
        divisor  = DVW'(n_v * p_v);
    end
endmodule

// File: rtl/pll_iter_div.sv
// Restoring divider retiring RB quotient bits per cycle. Assumes a non-zero
// divisor; vld pulses once, STEPS cycles after start.
module pll_iter_div #(
    parameter int AW  = 36,
    parameter int DVW = 10,
    parameter int RB  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic [AW-1:0]  quo,
    output logic           vld
);
    localparam int STEPS = (AW + RB - 1) / RB;
    localparam int PW    = STEPS * RB;
    localparam int RW    = DVW + 1;
    localparam int CW    = $clog2(STEPS + 1);

    logic [PW-1:0]  work, work_n;
    logic [RW-1:0]  rem, rem_n;
    logic [DVW-1:0] den;
    logic [AW-1:0]  quo_n;
    logic [CW-1:0]  cnt;
    logic           run;

    // RB unrolled shift-subtract stages for one cycle.
    always_comb begin
        logic [RW-1:0] sh;
        rem_n  = rem;
        work_n = work;
        quo_n  = quo;
        for (int k = 0; k < RB; k++) begin
            sh     = {rem_n[RW-2:0], work_n[PW-1]};
            work_n = work_n << 1;
            if (sh >= {1'b0, den}) begin
                rem_n = sh - {1'b0, den};
                quo_n = {quo_n[AW-2:0], 1'b1};
            end else begin
                rem_n = sh;
                quo_n = {quo_n[AW-2:0], 1'b0};
            end
        end
    end

    // Operand load, step sequencing and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work <= '0;
            rem  <= '0;
            den  <= '0;
            quo  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            vld  <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (start) begin
                work <= PW'(dividend);
                rem  <= '0;
                den  <= divisor;
                quo  <= '0;
                cnt  <= CW'(STEPS);
                run  <= 1'b1;
            end else if (run) begin
                work <= work_n;
                rem  <= rem_n;
                quo  <= quo_n;
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    vld <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pll_div_search.sv
// Top of the divider search unit. Sequences walker, screen and divider,
// keeps the exact or nearest-above candidate, and gates results with found.
// Assumes start is ignored while busy and results hold until the next start.
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int DIV_RB = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [PIX_W-1:0]              pix_khz,
    output logic                          busy,
    output logic                          done,
    output logic                          found,
    output logic                          bad_clk,
    output logic [pll_search_pkg::FW-1:0] n_o,
    output logic [pll_search_pkg::FW-1:0] m1_o,
    output logic [pll_search_pkg::FW-1:0] m2_o,
    output logic [pll_search_pkg::FW-1:0] p1_o,
    output logic [pll_search_pkg::FW-1:0] p2_o,
    output logic [2:0]                    mult_o,
    output logic [pll_search_pkg::WW-1:0] div_word
);
    st_t             st;
    logic [2:0]      sel_mult, mult_q;
    logic [TW-1:0]   sel_target, target_q, best_diff, diff;
    logic            sel_slow, found_q, bad_q, done_q;
    cand_t           cand, best;
    logic            last, cand_ok, div_vld;
    logic            walk_load, walk_step, div_go;
    logic [AW-1:0]   dvd, dot;
    logic [DVW-1:0]  dvs;
    logic            in_range, is_exact, better;

    pll_mult_select #(.PIX_W(PIX_W), .TW(TW)) u_mult (
        .pix_khz(pix_khz), .mult(sel_mult), .target_hz(sel_target), .too_slow(sel_slow)
    );

    pll_cand_walker u_walk (
        .clk(clk), .rst_n(rst_n), .load(walk_load), .step(walk_step), .cand(cand), .last(last)
    );

    pll_cand_check u_chk (
        .cand(cand), .ok(cand_ok), .dividend(dvd), .divisor(dvs)
    );

    pll_iter_div #(.AW(AW), .DVW(DVW), .RB(DIV_RB)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_go), .dividend(dvd), .divisor(dvs),
        .quo(dot), .vld(div_vld)
    );

    // Judge the divided dot clock against range, target and running best.
    always_comb begin
        in_range = (dot >= AW'(DOT_MIN)) && (dot <= AW'(DOT_MAX));
        is_exact = in_range && (dot == AW'(target_q));
        diff     = TW'(dot - AW'(target_q));
        better   = in_range && (dot > AW'(target_q)) && (diff < best_diff);
    end

    // Walker and divider control strobes.
    always_comb begin
        walk_load = (st == ST_IDLE) && start && !sel_slow;
        div_go    = (st == ST_CHECK) && cand_ok;
        walk_step = ((st == ST_CHECK) && !cand_ok && !last) ||
                    ((st == ST_DIV) && div_vld && !is_exact && !last);
    end

    // Search sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            mult_q    <= '0;
            target_q  <= '0;
            best      <= '0;
            best_diff <= '1;
            found_q   <= 1'b0;
            bad_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        found_q   <= 1'b0;
                        bad_q     <= sel_slow;
                        best      <= '0;
                        best_diff <= '1;
                        target_q  <= sel_target;
                        mult_q    <= sel_mult;
                        if (sel_slow) done_q <= 1'b1;
                        else          st     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cand_ok) begin
                        st <= ST_DIV;
                    end else if (last) begin
                        done_q  <= 1'b1;
                        found_q <= (best.n != '0);
                        st      <= ST_IDLE;
                    end
                end
                ST_DIV: begin
                    if (div_vld) begin
                        if (is_exact) begin
                            best    <= cand;
                            found_q <= 1'b1;
                            done_q  <= 1'b1;
                            st      <= ST_IDLE;
                        end else begin
                            if (better) begin
                                best      <= cand;
                                best_diff <= diff;
                            end
                            if (last) begin
                                done_q  <= 1'b1;
                                found_q <= better || (best.n != '0);
                                st      <= ST_IDLE;
                            end else begin
                                st <= ST_CHECK;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Outputs: results are visible only when a candidate qualified.
    always_comb begin
        busy     = (st != ST_IDLE);
        done     = done_q;
        found    = found_q;
        bad_clk  = bad_q;
        n_o      = found_q ? best.n  : '0;
        m1_o     = found_q ? best.m1 : '0;
        m2_o     = found_q ? best.m2 : '0;
        p1_o     = found_q ? best.p1 : '0;
        p2_o     = found_q ? FW'(P2_FIX) : '0;
        mult_o   = found_q ? mult_q : '0;
        div_word = found_q ? {best.n - FW'(2), best.m1 - FW'(2), best.m2 - FW'(2)} : '0;
    end
endmodule

// File: rtl/pll_div_search_chk.sv
// Property checker for the divider search unit, bound to the top module.
module pll_div_search_chk
    import pll_search_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic          bad_clk,
    input logic [FW-1:0] n_o,
    input logic [FW-1:0] m1_o,
    input logic [FW-1:0] m2_o,
    input logic [FW-1:0] p1_o,
    input logic [FW-1:0] p2_o,
    input logic [2:0]    mult_o,
    input logic [WW-1:0] div_word
);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_hides_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !found);

    p_found_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> done);

    p_p2_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (p2_o == FW'(P2_FIX)));

    p_limits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (n_o >= FW'(N_MIN) && n_o <= FW'(N_MAX) && m1_o > m2_o &&
                   p1_o >= FW'(P1_MIN) && p1_o <= FW'(P1_MAX) &&
                   (16'(m1_o) * 16'd5 + 16'(m2_o)) >= 16'(M_MIN) &&
                   (16'(m1_o) * 16'd5 + 16'(m2_o)) <= 16'(M_MAX)));

    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (n_o == '0 && m1_o == '0 && m2_o == '0 && p1_o == '0 &&
                              p2_o == '0 && mult_o == '0 && div_word == '0));

    p_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad_clk) |-> !found);
endmodule

bind pll_div_search pll_div_search_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .found(found),
    .bad_clk(bad_clk), .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o),
    .p2_o(p2_o), .mult_o(mult_o), .div_word(div_word)
);

// File: tb/pll_div_search_tb_top.sv
// Bench: sweeps pixel clocks across all multiplier bands and edges, with an
// arithmetic model of the ordered search computing each expected result.
module pll_div_search_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] pix_khz = '0;
    logic        busy, done, found, bad_clk;
    logic [7:0]  n_o, m1_o, m2_o, p1_o, p2_o;
    logic [2:0]  mult_o;
    logic [23:0] div_word;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_div_search dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz),
        .busy(busy), .done(done), .found(found), .bad_clk(bad_clk),
        .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o), .p2_o(p2_o),
        .mult_o(mult_o), .div_word(div_word)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Ordered search model written from the requirements.
    task automatic model(input int pix, output bit f, output bit bad,
                         output int rn, output int rm1, output int rm2,
                         output int rp1, output int rmult);
        longint tgt, best_d, m, p, vco, dot, d;
        int mult;
        f = 0; rn = 0; rm1 = 0; rm2 = 0; rp1 = 0; rmult = 0;
        bad = (pix < 25000);
        mult = (pix >= 100000) ? 1 : (pix >= 50000) ? 2 : 4;
        if (bad) return;
        tgt = longint'(pix) * 1000 * mult;
        best_d = 64'hFFFF_FFFF;
        for (int n = 3; n <= 8; n++)
            for (int m1 = 20; m1 >= 10; m1--)
                for (int m2 = 9; m2 >= 5; m2--)
                    for (int p1 = 8; p1 >= 1; p1--) begin
                        m = 5 * m1 + m2;
                        p = 10 * p1;
                        if (m1 <= m2 || m < 70 || m > 120 || p < 5 || p > 80) continue;
                        vco = 64'd96_000_000 * m / n;
                        dot = vco / p;
                        if (dot < 20_000_000 || dot > 400_000_000) continue;
                        if (vco < 1_400_000_000 || vco > 64'd2_800_000_000) continue;
                        if (dot == tgt) begin
                            f = 1; rn = n; rm1 = m1; rm2 = m2; rp1 = p1; rmult = mult;
                            return;
                        end
                        d = dot - tgt;
                        if (dot > tgt && d < best_d) begin
                            best_d = d; f = 1; rn = n; rm1 = m1; rm2 = m2; rp1 = p1;
                        end
                    end
        rmult = f ? mult : 0;
    endtask

    // Compare the present outputs with the model result for pix.
    task automatic compare(input int pix, input string tag);
        bit f, bad;
        int en, em1, em2, ep1, emult;
        longint word, vco, dot;
        model(pix, f, bad, en, em1, em2, ep1, emult);
        word = f ? ((longint'(en - 2) << 16) | (longint'(em1 - 2) << 8) | longint'(em2 - 2)) : 0;
        chk($sformatf("%s found pix=%0d", tag, pix), found, f);
        chk($sformatf("R2 bad_clk pix=%0d", pix), bad_clk, bad);
        chk($sformatf("%s n pix=%0d", tag, pix), n_o, en);
        chk($sformatf("%s m1 pix=%0d", tag, pix), m1_o, em1);
        chk($sformatf("%s m2 pix=%0d", tag, pix), m2_o, em2);
        chk($sformatf("%s p1 pix=%0d", tag, pix), p1_o, ep1);
        chk($sformatf("R8 p2 pix=%0d", pix), p2_o, f ? 10 : 0);
        chk($sformatf("R1 mult pix=%0d", pix), mult_o, emult);
        chk($sformatf("R6 word pix=%0d", pix), div_word, word);
        if (found) begin
            vco = 64'd96_000_000 * (5 * longint'(m1_o) + m2_o) / n_o;
            dot = vco / (10 * longint'(p1_o));
            chk($sformatf("R3 vco window pix=%0d", pix),
                (vco >= 1_400_000_000 && vco <= 64'd2_800_000_000) ? 1 : 0, 1);
            chk($sformatf("R3 dot window pix=%0d", pix),
                (dot >= 20_000_000 && dot <= 400_000_000) ? 1 : 0, 1);
        end
    endtask

    task automatic issue(input int pix);
        @(negedge clk);
        pix_khz = 20'(pix);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done;
        while (!done) @(negedge clk);
    endtask

    task automatic run(input int pix, input string tag);
        issue(pix);
        if (pix >= 25000) chk($sformatf("R11 busy after start pix=%0d", pix), busy, 1);
        wait_done();
        compare(pix, tag);
        @(negedge clk);
        chk($sformatf("R11 done one cycle pix=%0d", pix), done, 0);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset.
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 found", found, 0);
        chk("R10 bad_clk", bad_clk, 0);
        chk("R10 word", div_word, 0);
        chk("R10 n", n_o, 0);

        // R2: just below the floor is refused in one cycle.
        issue(24999);
        chk("R2 done next cycle", done, 1);
        chk("R2 busy low", busy, 0);
        compare(24999, "R2");

        run(25000, "R5");     // floor, multiplier 4
        run(49999, "R5");     // top of multiplier-4 band
        run(60000, "R4");     // exact hit exists (120 MHz)
        run(100000, "R5");    // bottom of multiplier-1 band
        run(400000, "R7");    // nothing lies above 400 MHz

        // R9: a second start during the search is ignored.
        issue(148500);
        repeat (40) @(negedge clk);
        chk("R9 still busy", busy, 1);
        pix_khz = 20'd30000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        compare(148500, "R9");

        // R11: start in the done cycle launches a new search.
        pix_khz = 20'd50000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 back-to-back busy", busy, 1);
        chk("R11 back-to-back done low", done, 0);
        wait_done();
        compare(50000, "R5");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule